// File: doc/BRIEF.md
# Mode-Indexed Epoch DMA Chain Dispatcher

This block takes a stream of words cut into epochs and turns it into memory write requests without any processor in the loop. In header mode the first word of each epoch is a sensor mode code. A mode map translates that code into the starting entry of a chain of command packets. The packets live in a small on-chip table. Each packet names a base address, the most words it may take, the entry that follows it, a branch entry, a flag marking it as a synchronisation point, and a flag closing the chain. Data words are written to consecutive word addresses from the current packet's base. When a packet fills, the engine moves on along the chain.

Every epoch boundary resets the engine's chain position, so a fault costs at most one epoch. When no header is used, the branch entry of the packet active at the boundary selects the next epoch's chain, so a planned mode change or an early-end recovery takes effect on the next epoch. A packet marked as a synchronisation point emits a four-word status block on the same write port. An optional one-cycle mailbox interrupt follows it. Four framing options control how epoch ends are found. The table, map and configuration inputs are expected to be written while the stream is idle, followed by a reset of the engine.

Top module: `mode_chain_dma`

## Requirements
- R1: In header mode (framing single, dynamic or fixed, with header enabled) the first accepted word of an epoch is taken as the mode code and is not written. A code below the mode count that has a valid map entry starts the epoch at that entry. Data word k of a packet goes to the packet base plus k.
- R2: When a packet that is not marked last reaches its maximum word count before the epoch ends, the following words go to the packet named by its next index, starting at offset 0.
- R3: When a packet marked last fills in a framed mode, every further word of that epoch is accepted and dropped, and error bit 1 (overflow) is set. No write ever reaches an address at or beyond base plus maximum count.
- R4: An epoch that ends while the current packet holds fewer words than its maximum sets error bit 0 (early end). An epoch whose final word exactly fills the packet does not set it.
- R5: Every epoch boundary discards the chain position, offset and overflow state, so the next epoch starts cleanly from its own header word.
- R6: With the header disabled, the first epoch after reset starts at the default start entry, and each later epoch starts at the branch index of the packet that was active when the previous epoch ended.
- R7: A mode code that is out of range, or whose map entry is not valid, discards the epoch up to its end. No data is written for it, and a status block is issued with error bit 2 (unknown mode) and a word count of 0.
- R8: A status block is four writes, flagged by wr_is_stat, to the status address plus 0, 1, 2 and 3. They carry the mode word, the data words written in the epoch so far, the error bits, and the epoch sequence number (0 for the first epoch after reset). The block is issued when a sync packet is left by filling or is active when the epoch ends. If the interrupt is enabled, mbox_irq pulses for one cycle right after the fourth status write is accepted.
- R9: Framing code 2'b00 (unframed) takes no mode word and ignores in_eoe. The stream starts at the default entry, and a filled last packet continues at its branch index.
- R10: Framing code 2'b11 (fixed) ends each epoch after cfg_frame_len accepted words, counting the header word, and ignores in_eoe.
- R11: Framing code 2'b01 (single) handles only the first epoch after reset. All later input is accepted and dropped without any write. Framing code 2'b10 (dynamic) ends each epoch on the word carrying in_eoe.
- R12: While wr_valid is high and wr_ready is low, wr_addr, wr_data and wr_is_stat stay stable. Backpressure stalls the input and never loses or reorders a word.
- R13: During reset wr_valid and mbox_irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_framing | input | 2 | Framing option: 00 unframed, 01 single, 10 dynamic, 11 fixed |
| cfg_hdr_en | input | 1 | Take the first epoch word as the mode code |
| cfg_dflt_start | input | IDX_W | Start entry when no header is used |
| cfg_frame_len | input | CNT_W | Epoch length in words for fixed framing |
| cfg_stat_addr | input | ADDR_W | Base address of the status block |
| cfg_irq_en | input | 1 | Enable the mailbox pulse |
| tbl_we | input | 1 | Write one command table entry |
| tbl_idx | input | IDX_W | Entry to write |
| tbl_base | input | ADDR_W | Entry base address |
| tbl_max | input | CNT_W | Entry maximum word count |
| tbl_next | input | IDX_W | Entry next index |
| tbl_branch | input | IDX_W | Entry branch index |
| tbl_sync | input | 1 | Entry is a synchronisation point |
| tbl_last | input | 1 | Entry closes its chain |
| map_we | input | 1 | Write one mode map entry |
| map_code | input | CODE_W | Mode code to map |
| map_start | input | IDX_W | Start entry for that code |
| map_ok | input | 1 | Map entry valid |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | DATA_W | Input word |
| in_eoe | input | 1 | Word is the last of its epoch |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | ADDR_W | Write word address |
| wr_data | output | DATA_W | Write data |
| wr_is_stat | output | 1 | Write belongs to a status block |
| mbox_irq | output | 1 | One-cycle mailbox pulse |

## Verification
A data word accepted at a clock edge appears on the write port in the following cycle. Status words follow one per free output cycle, starting in the cycle after the word that completes the sync packet. The mailbox pulse is high in the cycle after the fourth status word is handed off. The bench records every accepted write at the clock edge where it is handed off. After each scenario it lets the stream drain for thirty idle cycles and then compares the recorded writes, in order, against the sequence worked out from the table contents. This way the checks depend on order and contents, not on the exact cycle each write lands. The mailbox pulses are counted over the same window. Runs with random backpressure must give exactly the same write list as runs without it.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    typedef enum logic [1:0] {
        FRM_NONE = 2'b00,
        FRM_ONE  = 2'b01,
        FRM_DYN  = 2'b10,
        FRM_FIX  = 2'b11
    } frm_e;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_HDR,
        ST_RUN,
        ST_DROP,
        ST_STAT,
        ST_DONE
    } st_e;

    localparam int ERR_EARLY  = 0;
    localparam int ERR_OVF    = 1;
    localparam int ERR_UNK    = 2;
    localparam int ERR_W      = 3;
    localparam int STAT_WORDS = 4;

endpackage

// File: rtl/mcd_cmd_table.sv
module mcd_cmd_table #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [ADDR_W-1:0] wbase,
    input  logic [CNT_W-1:0]  wmax,
    input  logic [IDX_W-1:0]  wnext,
    input  logic [IDX_W-1:0]  wbranch,
    input  logic              wsync,
    input  logic              wlast,
    input  logic [IDX_W-1:0]  ridx,
    output logic [ADDR_W-1:0] rbase,
    output logic [CNT_W-1:0]  rmax,
    output logic [IDX_W-1:0]  rnext,
    output logic [IDX_W-1:0]  rbranch,
    output logic              rsync,
    output logic              rlast
);
    logic [ADDR_W-1:0] base_q   [DEPTH];
    logic [CNT_W-1:0]  max_q    [DEPTH];
    logic [IDX_W-1:0]  next_q   [DEPTH];
    logic [IDX_W-1:0]  branch_q [DEPTH];
    logic              sync_q   [DEPTH];
    logic              last_q   [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[i]   <= '0;
                max_q[i]    <= '0;
                next_q[i]   <= '0;
                branch_q[i] <= '0;
                sync_q[i]   <= 1'b0;
                last_q[i]   <= 1'b1;
            end else if (we && widx == IDX_W'(i)) begin
                base_q[i]   <= wbase;
                max_q[i]    <= wmax;
                next_q[i]   <= wnext;
                branch_q[i] <= wbranch;
                sync_q[i]   <= wsync;
                last_q[i]   <= wlast;
            end
        end
    end

    assign rbase   = base_q[ridx];
    assign rmax    = max_q[ridx];
    assign rnext   = next_q[ridx];
    assign rbranch = branch_q[ridx];
    assign rsync   = sync_q[ridx];
    assign rlast   = last_q[ridx];
endmodule

// File: rtl/mcd_mode_lut.sv
module mcd_mode_lut #(
    parameter int MODES = 8,
    parameter int DEPTH = 16,
    localparam int CODE_W = $clog2(MODES),
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CODE_W-1:0] wcode,
    input  logic [IDX_W-1:0]  wstart,
    input  logic              wok,
    input  logic [CODE_W-1:0] code,
    output logic [IDX_W-1:0]  start,
    output logic              ok
);
    logic [IDX_W-1:0] start_q [MODES];
    logic             ok_q    [MODES];

    for (genvar m = 0; m < MODES; m++) begin : g_map
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                start_q[m] <= '0;
                ok_q[m]    <= 1'b0;
            end else if (we && wcode == CODE_W'(m)) begin
                start_q[m] <= wstart;
                ok_q[m]    <= wok;
            end
        end
    end

    assign start = start_q[code];
    assign ok    = ok_q[code];
endmodule

// File: rtl/mcd_epoch_track.sv
module mcd_epoch_track
    import mcd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       framing,
    input  logic [CNT_W-1:0] frame_len,
    input  logic             acc,
    input  logic             eoe,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        unique case (frm_e'(framing))
            FRM_NONE: last = 1'b0;
            FRM_FIX:  last = (cnt_q == frame_len - 1'b1);
            default:  last = eoe;
        endcase
        cnt_d = cnt_q;
        if (acc) cnt_d = last ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mode_chain_dma.sv
module mode_chain_dma
    import mcd_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter int TBL_DEPTH = 16,
    parameter int MODES     = 8,
    localparam int IDX_W    = $clog2(TBL_DEPTH),
    localparam int CODE_W   = $clog2(MODES),
    localparam int WCNT_W   = CNT_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_framing,
    input  logic              cfg_hdr_en,
    input  logic [IDX_W-1:0]  cfg_dflt_start,
    input  logic [CNT_W-1:0]  cfg_frame_len,
    input  logic [ADDR_W-1:0] cfg_stat_addr,
    input  logic              cfg_irq_en,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [CNT_W-1:0]  tbl_max,
    input  logic [IDX_W-1:0]  tbl_next,
    input  logic [IDX_W-1:0]  tbl_branch,
    input  logic              tbl_sync,
    input  logic              tbl_last,
    input  logic              map_we,
    input  logic [CODE_W-1:0] map_code,
    input  logic [IDX_W-1:0]  map_start,
    input  logic              map_ok,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_eoe,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_is_stat,
    output logic              mbox_irq
);
    typedef struct packed {
        st_e               st;
        st_e               ret;
        logic [IDX_W-1:0]  cur;
        logic [CNT_W-1:0]  cnt;
        logic              ovf;
        logic [DATA_W-1:0] mode;
        logic [WCNT_W-1:0] words;
        logic [ERR_W-1:0]  err;
        logic [DATA_W-1:0] seq;
        logic [DATA_W-1:0] snap_mode;
        logic [WCNT_W-1:0] snap_words;
        logic [ERR_W-1:0]  snap_err;
        logic [DATA_W-1:0] snap_seq;
        logic [1:0]        sidx;
        logic              wr_valid;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
        logic              wr_stat;
        logic              wr_slast;
        logic              irq;
    } state_t;

    state_t r_q, r_d;

    logic [ADDR_W-1:0] ent_base;
    logic [CNT_W-1:0]  ent_max;
    logic [IDX_W-1:0]  ent_next, ent_branch, lut_start;
    logic              ent_sync, ent_last, lut_ok;
    logic              last_w, acc, rdy, slot_free, hdr_eff, unframed, code_ok, full, ep_end;
    logic [CNT_W-1:0]  cnt_inc;
    st_e               after;

    mcd_cmd_table #(.DEPTH(TBL_DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx), .wbase(tbl_base),
        .wmax(tbl_max), .wnext(tbl_next), .wbranch(tbl_branch), .wsync(tbl_sync),
        .wlast(tbl_last), .ridx(r_q.cur), .rbase(ent_base), .rmax(ent_max),
        .rnext(ent_next), .rbranch(ent_branch), .rsync(ent_sync), .rlast(ent_last)
    );

    mcd_mode_lut #(.MODES(MODES), .DEPTH(TBL_DEPTH)) u_lut (
        .clk(clk), .rst_n(rst_n), .we(map_we), .wcode(map_code), .wstart(map_start),
        .wok(map_ok), .code(in_data[CODE_W-1:0]), .start(lut_start), .ok(lut_ok)
    );

    mcd_epoch_track #(.CNT_W(CNT_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .framing(cfg_framing), .frame_len(cfg_frame_len),
        .acc(acc), .eoe(in_eoe), .last(last_w)
    );

    assign unframed  = (frm_e'(cfg_framing) == FRM_NONE);
    assign hdr_eff   = cfg_hdr_en && !unframed;
    assign slot_free = !r_q.wr_valid || wr_ready;
    assign code_ok   = (in_data < DATA_W'(MODES)) && lut_ok;
    assign cnt_inc   = r_q.cnt + 1'b1;
    assign full      = (cnt_inc >= ent_max);
    assign acc       = in_valid && rdy;

    always_comb begin
        unique case (r_q.st)
            ST_HDR, ST_DROP, ST_DONE: rdy = 1'b1;
            ST_RUN:                   rdy = slot_free;
            default:                  rdy = 1'b0;
        endcase
        if (frm_e'(cfg_framing) == FRM_ONE) after = ST_DONE;
        else if (hdr_eff)                   after = ST_HDR;
        else                                after = ST_RUN;
    end

    always_comb begin
        r_d    = r_q;
        r_d.irq = 1'b0;
        ep_end = 1'b0;
        if (r_q.wr_valid && wr_ready) begin
            r_d.wr_valid = 1'b0;
            r_d.irq      = r_q.wr_slast && cfg_irq_en;
        end
        unique case (r_q.st)
            ST_INIT: begin
                r_d.st   = hdr_eff ? ST_HDR : ST_RUN;
                r_d.cur  = cfg_dflt_start;
                r_d.mode = '0;
            end
            ST_HDR: if (acc) begin
                r_d.mode  = in_data;
                r_d.words = '0;
                r_d.err   = '0;
                r_d.cnt   = '0;
                r_d.ovf   = 1'b0;
                if (code_ok) begin
                    r_d.cur = lut_start;
                    if (last_w) begin
                        r_d.seq = r_q.seq + 1'b1;
                        r_d.st  = after;
                    end else begin
                        r_d.st = ST_RUN;
                    end
                end else begin
                    r_d.err[ERR_UNK] = 1'b1;
                    if (last_w) begin
                        r_d.snap_mode  = in_data;
                        r_d.snap_words = '0;
                        r_d.snap_err   = r_d.err;
                        r_d.snap_seq   = r_q.seq;
                        r_d.seq        = r_q.seq + 1'b1;
                        r_d.err        = '0;
                        r_d.st         = ST_STAT;
                        r_d.ret        = after;
                    end else begin
                        r_d.st = ST_DROP;
                    end
                end
            end
            ST_RUN: if (acc) begin
                if (r_q.ovf) begin
                    r_d.err[ERR_OVF] = 1'b1;
                    ep_end = last_w;
                end else begin
                    r_d.wr_valid = 1'b1;
                    r_d.wr_addr  = ent_base + {{(ADDR_W-CNT_W){1'b0}}, r_q.cnt};
                    r_d.wr_data  = in_data;
                    r_d.wr_stat  = 1'b0;
                    r_d.wr_slast = 1'b0;
                    r_d.words    = r_q.words + 1'b1;
                    r_d.cnt      = cnt_inc;
                    if (last_w) begin
                        if (!full) r_d.err[ERR_EARLY] = 1'b1;
                        ep_end = 1'b1;
                    end else if (full) begin
                        if (ent_last && !unframed) begin
                            r_d.ovf = 1'b1;
                        end else begin
                            r_d.cur = ent_last ? ent_branch : ent_next;
                            r_d.cnt = '0;
                            if (ent_sync) begin
                                r_d.snap_mode  = r_q.mode;
                                r_d.snap_words = r_d.words;
                                r_d.snap_err   = r_d.err;
                                r_d.snap_seq   = r_q.seq;
                                r_d.st         = ST_STAT;
                                r_d.ret        = ST_RUN;
                            end
                        end
                    end
                end
                if (ep_end) begin
                    r_d.seq = r_q.seq + 1'b1;
                    r_d.cnt = '0;
                    r_d.ovf = 1'b0;
                    if (!hdr_eff) r_d.cur = ent_branch;
                    if (ent_sync) begin
                        r_d.snap_mode  = r_q.mode;
                        r_d.snap_words = r_d.words;
                        r_d.snap_err   = r_d.err;
                        r_d.snap_seq   = r_q.seq;
                        r_d.st         = ST_STAT;
                        r_d.ret        = after;
                    end else begin
                        r_d.st = after;
                    end
                    r_d.words = '0;
                    r_d.err   = '0;
                end
            end
            ST_DROP: if (acc && last_w) begin
                r_d.snap_mode  = r_q.mode;
                r_d.snap_words = '0;
                r_d.snap_err   = r_q.err;
                r_d.snap_seq   = r_q.seq;
                r_d.seq        = r_q.seq + 1'b1;
                r_d.err        = '0;
                r_d.st         = ST_STAT;
                r_d.ret        = after;
            end
            ST_STAT: if (slot_free) begin
                r_d.wr_valid = 1'b1;
                r_d.wr_addr  = cfg_stat_addr + {{(ADDR_W-2){1'b0}}, r_q.sidx};
                r_d.wr_stat  = 1'b1;
                r_d.wr_slast = (r_q.sidx == 2'd3);
                unique case (r_q.sidx)
                    2'd0:    r_d.wr_data = r_q.snap_mode;
                    2'd1:    r_d.wr_data = {{(DATA_W-WCNT_W){1'b0}}, r_q.snap_words};
                    2'd2:    r_d.wr_data = {{(DATA_W-ERR_W){1'b0}}, r_q.snap_err};
                    default: r_d.wr_data = r_q.snap_seq;
                endcase
                r_d.sidx = r_q.sidx + 1'b1;
                if (r_q.sidx == 2'd3) r_d.st = r_q.ret;
            end
            ST_DONE: ;
            default: r_d.st = ST_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_INIT;
            r_q.ret <= ST_INIT;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready   = rdy;
    assign wr_valid   = r_q.wr_valid;
    assign wr_addr    = r_q.wr_addr;
    assign wr_data    = r_q.wr_data;
    assign wr_is_stat = r_q.wr_stat;
    assign mbox_irq   = r_q.irq;
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_is_stat,
    input logic [ADDR_W-1:0] cfg_stat_addr,
    input logic              mbox_irq
);
    a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)
                                     && $stable(wr_is_stat)));

    a_r8_irq_after_stat: assert property (@(posedge clk) disable iff (!rst_n)
        mbox_irq |-> $past(wr_valid && wr_ready && wr_is_stat));

    a_r8_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mbox_irq |=> !mbox_irq);

    a_r8_stat_window: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_is_stat) |-> ((wr_addr - cfg_stat_addr) < ADDR_W'(4)));

    a_r13_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!wr_valid && !mbox_irq));
endmodule

bind mode_chain_dma mcd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_is_stat(wr_is_stat),
    .cfg_stat_addr(cfg_stat_addr), .mbox_irq(mbox_irq)
);

// File: tb/sim_mode_chain_dma.sv
module sim_mode_chain_dma;
    localparam int IDX_W = 4;
    localparam int CODE_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]  cfg_framing = 2'b10;
    logic        cfg_hdr_en = 1'b1;
    logic [IDX_W-1:0] cfg_dflt_start = '0;
    logic [15:0] cfg_frame_len = 16'd4;
    logic [31:0] cfg_stat_addr = 32'hF000;
    logic        cfg_irq_en = 1'b1;
    logic        tbl_we = 1'b0;
    logic [IDX_W-1:0] tbl_idx = '0;
    logic [31:0] tbl_base = '0;
    logic [15:0] tbl_max = '0;
    logic [IDX_W-1:0] tbl_next = '0, tbl_branch = '0;
    logic        tbl_sync = 1'b0, tbl_last = 1'b0;
    logic        map_we = 1'b0;
    logic [CODE_W-1:0] map_code = '0;
    logic [IDX_W-1:0]  map_start = '0;
    logic        map_ok = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_eoe = 1'b0;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [31:0] wr_addr, wr_data;
    logic        wr_is_stat, mbox_irq;

    int nchk = 0, nerr = 0;
    logic [31:0] cap_a [256];
    logic [31:0] cap_d [256];
    logic        cap_s [256];
    int ncap = 0, irq_cnt = 0;
    logic [31:0] exp_a [64];
    logic [31:0] exp_d [64];
    logic        exp_s [64];
    int nexp = 0, cap_from = 0, irq_from = 0;
    logic bp = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    always #5 clk = ~clk;

    mode_chain_dma u0 (
        .clk(clk), .rst_n(rst_n), .cfg_framing(cfg_framing), .cfg_hdr_en(cfg_hdr_en),
        .cfg_dflt_start(cfg_dflt_start), .cfg_frame_len(cfg_frame_len),
        .cfg_stat_addr(cfg_stat_addr), .cfg_irq_en(cfg_irq_en),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_base(tbl_base), .tbl_max(tbl_max),
        .tbl_next(tbl_next), .tbl_branch(tbl_branch), .tbl_sync(tbl_sync), .tbl_last(tbl_last),
        .map_we(map_we), .map_code(map_code), .map_start(map_start), .map_ok(map_ok),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_eoe(in_eoe),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_is_stat(wr_is_stat), .mbox_irq(mbox_irq)
    );

    always @(posedge clk) begin
        if (rst_n && wr_valid && wr_ready) begin
            if (ncap < 256) begin
                cap_a[ncap] = wr_addr;
                cap_d[ncap] = wr_data;
                cap_s[ncap] = wr_is_stat;
            end
            ncap = ncap + 1;
        end
        if (mbox_irq) irq_cnt = irq_cnt + 1;
    end

    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        wr_ready = bp ? lfsr[0] : 1'b1;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic send(input logic [31:0] d, input bit eoe);
        bit r;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_eoe   = eoe;
        forever begin
            #1 r = in_ready;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        in_eoe   = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic ew(input logic [31:0] a, input logic [31:0] d, input bit s);
        exp_a[nexp] = a;
        exp_d[nexp] = d;
        exp_s[nexp] = s;
        nexp++;
    endtask

    task automatic stat(input logic [31:0] m, input logic [31:0] w, input logic [31:0] e, input logic [31:0] q);
        ew(32'hF000, m, 1'b1);
        ew(32'hF001, w, 1'b1);
        ew(32'hF002, e, 1'b1);
        ew(32'hF003, q, 1'b1);
    endtask

    task automatic begin_scn();
        cap_from = ncap;
        irq_from = irq_cnt;
        nexp = 0;
    endtask

    task automatic end_scn(input string tag, input int irqs);
        idle(30);
        check(ncap - cap_from == nexp, {tag, " write count"}, ncap - cap_from, nexp);
        for (int i = 0; i < nexp; i++) begin
            if (cap_from + i < ncap && cap_from + i < 256) begin
                check(cap_a[cap_from+i] == exp_a[i], {tag, " addr"}, cap_a[cap_from+i], exp_a[i]);
                check(cap_d[cap_from+i] == exp_d[i], {tag, " data"}, cap_d[cap_from+i], exp_d[i]);
                check(cap_s[cap_from+i] == exp_s[i], {tag, " stat flag"},
                      32'(cap_s[cap_from+i]), 32'(exp_s[i]));
            end
        end
        check(irq_cnt - irq_from == irqs, {tag, " R8 irq count"}, irq_cnt - irq_from, irqs);
    endtask

    task automatic put_ent(input int i, input logic [31:0] b, input int m, input int nx,
                           input int br, input bit s, input bit l);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = IDX_W'(i); tbl_base = b; tbl_max = 16'(m);
        tbl_next = IDX_W'(nx); tbl_branch = IDX_W'(br); tbl_sync = s; tbl_last = l;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic put_map(input int c, input int st);
        @(negedge clk);
        map_we = 1'b1; map_code = CODE_W'(c); map_start = IDX_W'(st); map_ok = 1'b1;
        @(negedge clk);
        map_we = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(wr_valid == 1'b0, "R13 wr_valid in reset", 32'(wr_valid), 0);
        check(mbox_irq == 1'b0, "R13 irq in reset", 32'(mbox_irq), 0);
        rst_n = 1'b1;
        put_ent(0, 32'h1000, 4, 1, 5, 1'b0, 1'b0);
        put_ent(1, 32'h2000, 3, 0, 5, 1'b1, 1'b1);
        put_ent(2, 32'h3000, 2, 3, 0, 1'b0, 1'b0);
        put_ent(3, 32'h3100, 2, 0, 0, 1'b1, 1'b1);
        put_ent(5, 32'h5000, 8, 0, 0, 1'b1, 1'b1);
        put_map(0, 0);
        put_map(1, 2);
        put_map(3, 5);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        // dynamic framing with header
        cfg_framing = 2'b10; cfg_hdr_en = 1'b1; cfg_irq_en = 1'b1;
        restart();
        check(wr_valid == 1'b0, "R13 idle after reset", 32'(wr_valid), 0);

        // R1 R2 R8: exact fill of last packet with end marker
        begin_scn();
        send(0, 0);
        for (int i = 0; i < 7; i++) send(32'h100 + i, i == 6);
        for (int i = 0; i < 4; i++) ew(32'h1000 + i, 32'h100 + i, 0);
        for (int i = 0; i < 3; i++) ew(32'h2000 + i, 32'h104 + i, 0);
        stat(0, 7, 0, 0);
        end_scn("R1 R2 R8 chain", 1);

        // R4: early end inside second packet of mode 1
        begin_scn();
        send(1, 0);
        for (int i = 0; i < 3; i++) send(32'h200 + i, i == 2);
        ew(32'h3000, 32'h200, 0); ew(32'h3001, 32'h201, 0); ew(32'h3100, 32'h202, 0);
        stat(1, 3, 1, 1);
        end_scn("R4 early", 1);

        // R3: overflow past the last packet
        begin_scn();
        send(0, 0);
        for (int i = 0; i < 9; i++) send(32'h300 + i, i == 8);
        for (int i = 0; i < 4; i++) ew(32'h1000 + i, 32'h300 + i, 0);
        for (int i = 0; i < 3; i++) ew(32'h2000 + i, 32'h304 + i, 0);
        stat(0, 7, 2, 2);
        end_scn("R3 overflow", 1);

        // R7: unmapped code, and R5 clean restart afterwards
        begin_scn();
        send(2, 0);
        send(32'h400, 0); send(32'h401, 1);
        stat(2, 0, 4, 3);
        end_scn("R7 unknown", 1);

        // R12: backpressure, same result as unstalled run
        bp = 1'b1;
        begin_scn();
        send(0, 0);
        for (int i = 0; i < 7; i++) send(32'h500 + i, i == 6);
        for (int i = 0; i < 4; i++) ew(32'h1000 + i, 32'h500 + i, 0);
        for (int i = 0; i < 3; i++) ew(32'h2000 + i, 32'h504 + i, 0);
        stat(0, 7, 0, 4);
        end_scn("R12 R5 backpressure", 1);

        // R1: mode 3 maps to entry 5
        begin_scn();
        send(3, 0);
        for (int i = 0; i < 3; i++) send(32'h580 + i, i == 2);
        for (int i = 0; i < 3; i++) ew(32'h5000 + i, 32'h580 + i, 0);
        stat(3, 3, 1, 5);
        end_scn("R1 R12 map", 1);
        bp = 1'b0;

        // R6: headerless, branch chooses next epoch, irq disabled
        cfg_hdr_en = 1'b0; cfg_dflt_start = 4'd0; cfg_irq_en = 1'b0;
        restart();
        begin_scn();
        send(32'h600, 0); send(32'h601, 1);
        for (int i = 0; i < 3; i++) send(32'h610 + i, i == 2);
        ew(32'h1000, 32'h600, 0); ew(32'h1001, 32'h601, 0);
        for (int i = 0; i < 3; i++) ew(32'h5000 + i, 32'h610 + i, 0);
        stat(0, 3, 1, 1);
        end_scn("R6 branch", 0);

        // R10: fixed frames of four words, marker ignored
        cfg_framing = 2'b11; cfg_hdr_en = 1'b1; cfg_frame_len = 16'd4; cfg_irq_en = 1'b1;
        restart();
        begin_scn();
        send(1, 0); send(32'h700, 0); send(32'h701, 1); send(32'h702, 0);
        send(0, 0); send(32'h710, 0); send(32'h711, 0); send(32'h712, 0);
        ew(32'h3000, 32'h700, 0); ew(32'h3001, 32'h701, 0); ew(32'h3100, 32'h702, 0);
        stat(1, 3, 1, 0);
        for (int i = 0; i < 3; i++) ew(32'h1000 + i, 32'h710 + i, 0);
        end_scn("R10 fixed", 1);

        // R9: unframed, no mode word, marker ignored, last packet branches
        cfg_framing = 2'b00; cfg_dflt_start = 4'd2;
        restart();
        begin_scn();
        for (int i = 0; i < 6; i++) send(32'h800 + i, i == 1);
        ew(32'h3000, 32'h800, 0); ew(32'h3001, 32'h801, 0);
        ew(32'h3100, 32'h802, 0); ew(32'h3101, 32'h803, 0);
        stat(0, 4, 0, 0);
        ew(32'h1000, 32'h804, 0); ew(32'h1001, 32'h805, 0);
        end_scn("R9 unframed", 1);

        // R11: single frame then everything dropped
        cfg_framing = 2'b01; cfg_hdr_en = 1'b1;
        restart();
        begin_scn();
        send(1, 0); send(32'h900, 0); send(32'h901, 1);
        send(0, 0); send(32'h910, 0); send(32'h911, 1);
        ew(32'h3000, 32'h900, 0); ew(32'h3001, 32'h901, 0);
        end_scn("R11 single", 0);
        check(in_ready == 1'b1, "R11 input still drained", 32'(in_ready), 1);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule